// File: doc/BRIEF.md
# Edge-Activated DMA Request Sequencer

This block is the front end of one DMA channel. It watches an active-low request line from a peripheral. When the channel is open to requests and the line is seen low on a clock edge, the block holds one request. At the next bus break it drops that request and starts a transfer. Each transfer is a source read cycle followed by a destination write cycle, and each cycle is finished by a done handshake from the bus side.

While a transfer is running, the block watches the request line for a high level. This is the release half of the edge. Only once the line has been seen high does the block accept another low. This gives edge-style behaviour on a level-sampled pin.

A down-counter, loaded beforehand, counts completed writes. When the last transfer completes, the block raises an end flag, drops its own enable and stops taking requests. Software turns the channel on and off with a one-cycle register-write strobe that carries the new enable value.

Top module: `dma_req_sequencer`

## Requirements
- R1: During reset and on the first cycle after it, `rdStrobe`, `wrStrobe`, `xferEnd` and `chanEnabled` are all 0.
- R2: A cycle with `cfgWrite`=1 and `cfgEnable`=1 sets `chanEnabled` from the next cycle. The request line is first sampled on the edge after that write cycle, so a low level present only during the write cycle starts no transfer.
- R3: A held request starts a transfer (`rdStrobe` rises) only on an edge where `busBreak` is 1. The request is consumed on that edge. While `busBreak` stays 0, the request stays held and no cycle starts.
- R4: `rdStrobe` stays high until an edge with `rdDone`=1. On the following cycle `wrStrobe` is high, and it stays high until an edge with `wrDone`=1. The two strobes are never high together.
- R5: If `reqN` is sampled high on any edge from the first edge of the read cycle up to and including the edge that completes the write, acceptance reopens after the write. A later low then starts the next transfer.
- R6: If no high was sampled in that window, acceptance stays closed after the write. The first later edge that samples `reqN` high reopens it, and a low on the next edge is then held.
- R7: A low level sampled while acceptance is closed is ignored. Holding `reqN` low through and past a transfer yields exactly one transfer.
- R8: After a write completes, both strobes stay low for at least `GAP_CYCLES` cycles (default 2) before the next `rdStrobe`. With a request ready, the gap is exactly `GAP_CYCLES` cycles.
- R9: `countLoad`=1 loads `countValue` into the transfer counter. Each completed write decrements it. The write that takes it from 1 to 0 sets `xferEnd` and clears `chanEnabled`, and no further transfer starts. An enabling register write clears `xferEnd`.
- R10: A cycle with `cfgWrite`=1 and `cfgEnable`=0 drops both strobes and `chanEnabled` on the next cycle and discards any held request. Re-enabling alone does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | One-cycle register-write strobe for the channel enable |
| cfgEnable | input | 1 | Enable value written when `cfgWrite` is 1 |
| countLoad | input | 1 | Loads the transfer counter |
| countValue | input | CNT_W | Number of transfers to load |
| reqN | input | 1 | External request line, active low |
| busBreak | input | 1 | Bus is free for the DMA to take it this cycle |
| rdStrobe | output | 1 | Source read cycle in progress |
| rdDone | input | 1 | Read cycle completes on this edge |
| wrStrobe | output | 1 | Destination write cycle in progress |
| wrDone | input | 1 | Write cycle completes on this edge |
| xferEnd | output | 1 | Transfer count exhausted |
| chanEnabled | output | 1 | Channel enable state |

## Verification
The sensitive coincidence is the edge that completes the write cycle, because the release sampling of the request line lands on that same edge. A high level seen there must still count toward reopening acceptance, and a low level seen there must not be taken as a new request. The bench provokes this by holding `reqN` low through a whole transfer, and by pulsing it high for a single cycle inside a read that lasts several cycles. It then judges how many read cycles follow and how many idle cycles separate them, both against a cycle-level reference model and against fixed expected counts.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  // Strobes from the control FSM into the counter datapath
  typedef struct packed {
    logic decrement;  // a write completed and is counted
    logic clearEnd;   // enabling write clears the end flag
  } ctlStrobe_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrite,
  input  logic       cfgEnable,
  input  logic       reqN,
  input  logic       busBreak,
  input  logic       rdDone,
  input  logic       wrDone,
  input  logic       countIsLast,
  output logic       rdStrobe,
  output logic       wrStrobe,
  output logic       chanEnabled,
  output ctlStrobe_t strobes
);

  localparam int GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES - 1);

  phase_e           phase;
  logic             enableQ;
  logic             acceptOpen;  // a low sample may be held
  logic             reqHeld;     // request waiting for a bus break
  logic             highSeen;    // release level seen during the DMA cycle
  logic [GAP_W-1:0] gapCnt;
  logic             startXfer;
  logic             writeEnds;

  assign startXfer = reqHeld && busBreak && (gapCnt == '0);
  assign writeEnds = (phase == PH_WRITE) && wrDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ    <= 1'b0;
      acceptOpen <= 1'b0;
      reqHeld    <= 1'b0;
      highSeen   <= 1'b0;
      phase      <= PH_IDLE;
      gapCnt     <= '0;
    end else if (cfgWrite) begin
      // register write wins over everything; sampling begins on the next edge
      enableQ    <= cfgEnable;
      acceptOpen <= cfgEnable;
      reqHeld    <= 1'b0;
      highSeen   <= 1'b0;
      phase      <= PH_IDLE;
      gapCnt     <= '0;
    end else if (enableQ) begin
      if (acceptOpen && !reqN) reqHeld <= 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (startXfer) begin
            phase      <= PH_READ;
            reqHeld    <= 1'b0;
            acceptOpen <= 1'b0;
            highSeen   <= 1'b0;
          end else begin
            if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
            // late release: the first high sample reopens acceptance
            if (!acceptOpen && !reqHeld && reqN) acceptOpen <= 1'b1;
          end
        end
        PH_READ: begin
          highSeen <= highSeen | reqN;
          if (rdDone) phase <= PH_WRITE;
        end
        PH_WRITE: begin
          if (writeEnds) begin
            phase    <= PH_IDLE;
            gapCnt   <= GAP_LOAD;
            highSeen <= 1'b0;
            if (countIsLast) begin
              enableQ    <= 1'b0;
              acceptOpen <= 1'b0;
              reqHeld    <= 1'b0;
            end else begin
              acceptOpen <= highSeen | reqN;
            end
          end else begin
            highSeen <= highSeen | reqN;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign rdStrobe          = (phase == PH_READ);
  assign wrStrobe          = (phase == PH_WRITE);
  assign chanEnabled       = enableQ;
  assign strobes.decrement = enableQ && writeEnds && !cfgWrite;
  assign strobes.clearEnd  = cfgWrite && cfgEnable;

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countLoad,
  input  logic [CNT_W-1:0] countValue,
  input  ctlStrobe_t       strobes,
  output logic             countIsLast,
  output logic             xferEnd
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remaining;
  logic             endQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (countLoad) begin
      remaining <= countValue;
    end else if (strobes.decrement) begin
      remaining <= remaining - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endQ <= 1'b0;
    end else if (strobes.clearEnd) begin
      endQ <= 1'b0;
    end else if (strobes.decrement && (remaining == ONE)) begin
      endQ <= 1'b1;
    end
  end

  assign countIsLast = (remaining == ONE);
  assign xferEnd     = endQ;

endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer
  import dma_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int GAP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic             cfgEnable,
  input  logic             countLoad,
  input  logic [CNT_W-1:0] countValue,
  input  logic             reqN,
  input  logic             busBreak,
  output logic             rdStrobe,
  input  logic             rdDone,
  output logic             wrStrobe,
  input  logic             wrDone,
  output logic             xferEnd,
  output logic             chanEnabled
);

  ctlStrobe_t strobes;
  logic       countIsLast;

  dma_seq_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrite    (cfgWrite),
    .cfgEnable   (cfgEnable),
    .reqN        (reqN),
    .busBreak    (busBreak),
    .rdDone      (rdDone),
    .wrDone      (wrDone),
    .countIsLast (countIsLast),
    .rdStrobe    (rdStrobe),
    .wrStrobe    (wrStrobe),
    .chanEnabled (chanEnabled),
    .strobes     (strobes)
  );

  dma_seq_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .countLoad   (countLoad),
    .countValue  (countValue),
    .strobes     (strobes),
    .countIsLast (countIsLast),
    .xferEnd     (xferEnd)
  );

endmodule

// File: rtl/dma_req_sequencer_checker.sv
module dma_req_sequencer_checker #(
  parameter int GAP_CYCLES = 2
) (
  input logic clk,
  input logic rstN,
  input logic cfgWrite,
  input logic cfgEnable,
  input logic busBreak,
  input logic rdStrobe,
  input logic rdDone,
  input logic wrStrobe,
  input logic wrDone,
  input logic xferEnd,
  input logic chanEnabled
);

  localparam int CW = $clog2(GAP_CYCLES + 2) + 1;

  logic [CW-1:0] idleCnt;
  logic          tracking;

  // idle cycles since the last completed write, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      tracking <= 1'b0;
    end else if (cfgWrite) begin
      tracking <= 1'b0;
    end else if (wrStrobe && wrDone) begin
      tracking <= 1'b1;
      idleCnt  <= '0;
    end else if (!rdStrobe && !wrStrobe && (idleCnt != '1)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  assert_read_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !rdDone && !cfgWrite) |=> rdStrobe);

  assert_read_to_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdDone && !cfgWrite) |=> (wrStrobe && !rdStrobe));

  assert_start_needs_break_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> $past(busBreak));

  assert_idle_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdStrobe) && tracking) |-> (int'(idleCnt) >= GAP_CYCLES));

  assert_end_drops_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferEnd) |-> !chanEnabled);

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnabled |-> (!rdStrobe && !wrStrobe));

  assert_disable_aborts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !cfgEnable) |=> (!rdStrobe && !wrStrobe && !chanEnabled));

endmodule

bind dma_req_sequencer dma_req_sequencer_checker #(.GAP_CYCLES(GAP_CYCLES)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWrite    (cfgWrite),
  .cfgEnable   (cfgEnable),
  .busBreak    (busBreak),
  .rdStrobe    (rdStrobe),
  .rdDone      (rdDone),
  .wrStrobe    (wrStrobe),
  .wrDone      (wrDone),
  .xferEnd     (xferEnd),
  .chanEnabled (chanEnabled)
);

// File: tb/dma_req_sequencer_bench.sv
`timescale 1ns/1ps
module dma_req_sequencer_bench;

  localparam int CNT_W  = 16;
  localparam int GAP    = 2;
  localparam int RD_LAT = 2;
  localparam int WR_LAT = 1;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgWrite, cfgEnable, countLoad;
  logic [CNT_W-1:0] countValue;
  logic             reqN, busBreak;
  logic             rdStrobe, rdDone, wrStrobe, wrDone, xferEnd, chanEnabled;

  always #10 clk = ~clk;  // 50 MHz

  dma_req_sequencer #(.CNT_W(CNT_W), .GAP_CYCLES(GAP)) u_dma_req_sequencer (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgEnable(cfgEnable),
    .countLoad(countLoad), .countValue(countValue), .reqN(reqN),
    .busBreak(busBreak), .rdStrobe(rdStrobe), .rdDone(rdDone),
    .wrStrobe(wrStrobe), .wrDone(wrDone), .xferEnd(xferEnd),
    .chanEnabled(chanEnabled)
  );

  int nCompared   = 0;
  int nMismatched = 0;
  bit finished    = 0;

  task automatic check(input string tag, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bus-side responder: done after a fixed number of waiting cycles
  int rdWait = 0, wrWait = 0;
  always @(negedge clk) begin
    if (rdStrobe) begin
      rdDone = (rdWait >= RD_LAT);
      rdWait = rdDone ? 0 : rdWait + 1;
    end else begin
      rdDone = 1'b0; rdWait = 0;
    end
    if (wrStrobe) begin
      wrDone = (wrWait >= WR_LAT);
      wrWait = wrDone ? 0 : wrWait + 1;
    end else begin
      wrDone = 1'b0; wrWait = 0;
    end
  end

  // behavioural reference: phase 0 idle, 1 read, 2 write
  bit mEn, mOpen, mHeld, mHigh, mEnd;
  int mPhase, mGap, mCount;
  // observation counters
  int rdStarts = 0, wrStarts = 0, idleRun = 0, minGap = 1000;
  bit prevRd = 0, prevWr = 0, sawWrEnd = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mOpen = 0; mHeld = 0; mHigh = 0; mEnd = 0;
      mPhase = 0; mGap = 0; mCount = 0;
    end else begin
      bit dec, last;
      dec  = !cfgWrite && mEn && (mPhase == 2) && wrDone;
      last = (mCount == 1);
      if (cfgWrite) begin
        mEn = cfgEnable; mOpen = cfgEnable; mHeld = 0; mHigh = 0;
        mPhase = 0; mGap = 0;
      end else if (mEn) begin
        if (mPhase == 0) begin
          if (mHeld && busBreak && mGap == 0) begin
            mPhase = 1; mHeld = 0; mOpen = 0; mHigh = 0;
          end else begin
            if (mOpen && !reqN) mHeld = 1;
            if (mGap > 0) mGap--;
            if (!mOpen && !mHeld && reqN) mOpen = 1;
          end
        end else if (mPhase == 1) begin
          if (reqN) mHigh = 1;
          if (rdDone) mPhase = 2;
        end else begin
          if (wrDone) begin
            bit reopen;
            reopen = mHigh || reqN;
            mPhase = 0; mGap = GAP - 1; mHigh = 0;
            if (last) begin mEn = 0; mOpen = 0; mHeld = 0; end
            else mOpen = reopen;
          end else if (reqN) mHigh = 1;
        end
      end
      if (countLoad) mCount = countValue;
      else if (dec) mCount = (mCount + 65535) % 65536;
      if (cfgWrite && cfgEnable) mEnd = 0;
      else if (dec && last) mEnd = 1;
    end
    #5;
    if (rstN) begin
      check("R4 rdStrobe vs model", rdStrobe, (mPhase == 1));
      check("R4 wrStrobe vs model", wrStrobe, (mPhase == 2));
      check("R9 xferEnd vs model", xferEnd, mEnd);
      check("R2 chanEnabled vs model", chanEnabled, mEn);
      if (rdStrobe && !prevRd) begin
        rdStarts++;
        if (sawWrEnd && idleRun < minGap) minGap = idleRun;
      end
      if (wrStrobe && !prevWr) wrStarts++;
      if (wrStrobe) begin idleRun = 0; sawWrEnd = 1; end
      else if (!rdStrobe) idleRun++;
      prevRd = rdStrobe; prevWr = wrStrobe;
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nMismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    rstN = 0; cfgWrite = 0; cfgEnable = 0; countLoad = 0; countValue = '0;
    reqN = 1; busBreak = 1; rdDone = 0; wrDone = 0;
    waitN(3);
    check("R1 rdStrobe in reset", rdStrobe, 0);
    check("R1 wrStrobe in reset", wrStrobe, 0);
    check("R1 xferEnd in reset", xferEnd, 0);
    check("R1 chanEnabled in reset", chanEnabled, 0);
    rstN = 1;
    waitN(1);
    check("R1 chanEnabled after reset", chanEnabled, 0);

    // R2: enable; a low present only during the write cycle is not taken
    countLoad = 1; countValue = 16'd5;
    waitN(1);
    countLoad = 0; cfgWrite = 1; cfgEnable = 1; reqN = 0;
    waitN(1);
    cfgWrite = 0; reqN = 1;
    check("R2 enable visible", chanEnabled, 1);
    waitN(6);
    check("R2 low during write cycle ignored", rdStarts, 0);

    // R3: held request waits for a bus break
    busBreak = 0; reqN = 0;
    waitN(1);
    reqN = 1;
    waitN(6);
    check("R3 no start without bus break", rdStarts, 0);
    busBreak = 1;
    waitN(12);
    check("R3 start at bus break", rdStarts, 1);

    // R7 / R6: low held throughout gives one transfer, then late release
    reqN = 0;
    waitN(30);
    check("R7 continuous low gives one transfer", rdStarts, 2);
    reqN = 1;
    waitN(1);
    reqN = 0;
    waitN(1);
    reqN = 1;
    waitN(15);
    check("R6 late high reopens acceptance", rdStarts, 3);

    // R5: one-cycle high inside the read re-arms; back-to-back to the end
    reqN = 0;
    wait (rdStrobe == 1'b1);
    waitN(1);
    reqN = 1;
    waitN(1);
    reqN = 0;
    waitN(25);
    check("R5 high inside read re-arms", rdStarts, 5);
    check("R4 one write per read", wrStarts, 5);
    check("R8 minimum idle gap", minGap, GAP);
    check("R9 end flag set", xferEnd, 1);
    check("R9 enable cleared at end", chanEnabled, 0);
    waitN(10);
    check("R9 no transfer after end", rdStarts, 5);

    // R9: enabling write clears the end flag
    reqN = 1; countLoad = 1; countValue = 16'd2;
    waitN(1);
    countLoad = 0; cfgWrite = 1; cfgEnable = 1;
    waitN(1);
    cfgWrite = 0;
    check("R9 end flag cleared by enable", xferEnd, 0);

    // R10: disable during a read aborts it
    reqN = 0;
    wait (rdStrobe == 1'b1);
    waitN(1);
    cfgWrite = 1; cfgEnable = 0;
    waitN(1);
    cfgWrite = 0;
    check("R10 read dropped on disable", rdStrobe, 0);
    check("R10 enable dropped", chanEnabled, 0);
    waitN(10);
    check("R10 no transfer while disabled", rdStarts, 6);

    // R10: a held request is discarded by disable
    reqN = 1; cfgWrite = 1; cfgEnable = 1;
    waitN(1);
    cfgWrite = 0; busBreak = 0; reqN = 0;
    waitN(1);
    reqN = 1;
    waitN(1);
    cfgWrite = 1; cfgEnable = 0;
    waitN(1);
    cfgEnable = 1;
    waitN(1);
    cfgWrite = 0; busBreak = 1;
    waitN(10);
    check("R10 held request discarded", rdStarts, 6);
    check("R10 re-enabled", chanEnabled, 1);

    finish_run();
  end

endmodule